// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block watches a small general-purpose port, by default 12 pins numbered 0 to 11, and turns pin activity into interrupt status. Each pin has its own settings: a direction bit, a choice between edge and level sensing, a both-edges override, a polarity bit and an enable mask. The pin inputs first pass through a two-stage synchronizer. Edge events are held in per-pin latches until software clears them. Level events follow the synchronized pin and are never held.

Software reaches the block through a simple register port. A write strobe carries an address and a data word. A read strobe returns the addressed word on the next cycle, flagged by a valid pulse. Raw status and masked status can be read back. A write-only clear register removes latched edges. A single registered interrupt line combines every enabled pending pin.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset every configuration register, both status words and `irq_o` read 0. Address 7 (clear) always reads 0.
- R2: Addresses 0 to 4 hold the direction, sense, both-edges, polarity and mask words. Bit i of each word belongs to pin i, and each reads back the last value written.
- R3: A pin with sense bit 0 and both-edges bit 0 latches on a rising edge when its polarity bit is 1, and on a falling edge when it is 0. The opposite edge is ignored. The latch stays set until it is cleared.
- R4: With sense bit 0 and both-edges bit 1, either edge sets the latch, whatever the polarity bit says.
- R5: With sense bit 1, raw status bit i is 1 while the synchronized pin equals polarity bit i (1 = HIGH, 0 = LOW). It is not latched, and the clear register does not change it.
- R6: Masked status (address 6) equals raw status (address 5) ANDed with the mask word. Mask bit 1 lets the pin through.
- R7: Writing address 7 clears the edge latch of each pin whose data bit is 1. Bits written as 0 leave their latches unchanged.
- R8: If a qualifying edge reaches the latch in the same cycle as a clear of that pin, the latch stays set.
- R9: `irq_o` is the OR of all masked status bits, registered one clock later.
- R10: A pin change made before clock edge 1 is seen by the detector after edge 2 and sets the edge latch at edge 3. A read sampled at edge 3 still returns the old raw value, and a read sampled at edge 4 returns the new one. `rd_data` and `rd_valid` appear one cycle after `rd_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | NPINS | Write data, one bit per pin |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Read address |
| rd_data | output | NPINS | Read data, valid with `rd_valid` |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| pin_i | input | NPINS | Asynchronous pin inputs |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is a clear that lands in the same cycle as a new edge on the same pin. The bench changes the pin and then counts exactly two falling clock edges. Its clear write then covers the clock edge where the synchronized edge reaches the latch, and a later raw read must still show the bit set. The same exact counting of clock edges shows the synchronizer delay: two back-to-back raw reads are placed so that the first samples just before the latch sets and the second just after. Level pins are checked to ignore a clear and to report a LOW-active pin as pending as soon as it is configured.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_DIR   = 3'd0,
    REG_SENSE = 3'd1,
    REG_BOTH  = 3'd2,
    REG_POL   = 3'd3,
    REG_MASK  = 3'd4,
    REG_RAW   = 3'd5,
    REG_MSKD  = 3'd6,
    REG_CLR   = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 12,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else begin
      stg[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];

  // R10
  stage_shift_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (stg[STAGES-1] == $past(stg[STAGES-2])));
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [NPINS-1:0]  wr_data,
  output logic [NPINS-1:0]  dir_q,
  output logic [NPINS-1:0]  sense_q,
  output logic [NPINS-1:0]  both_q,
  output logic [NPINS-1:0]  pol_q,
  output logic [NPINS-1:0]  mask_q,
  output logic [NPINS-1:0]  clr_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q   <= '0;
      sense_q <= '0;
      both_q  <= '0;
      pol_q   <= '0;
      mask_q  <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        REG_DIR:   dir_q   <= wr_data;
        REG_SENSE: sense_q <= wr_data;
        REG_BOTH:  both_q  <= wr_data;
        REG_POL:   pol_q   <= wr_data;
        REG_MASK:  mask_q  <= wr_data;
        default:   ;
      endcase
    end
  end

  // one-cycle clear pulse; the clear address has no storage
  assign clr_o = (wr_en && wr_addr == REG_CLR) ? wr_data : '0;

  // R2
  cfg_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == REG_MASK) |=> (mask_q == $past(wr_data)));
endmodule

// File: rtl/gpio_pin_detect.sv
module gpio_pin_detect #(
  parameter int NPINS = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pin_s,
  input  logic [NPINS-1:0] sense,
  input  logic [NPINS-1:0] both,
  input  logic [NPINS-1:0] pol,
  input  logic [NPINS-1:0] mask,
  input  logic [NPINS-1:0] clr,
  output logic [NPINS-1:0] raw,
  output logic [NPINS-1:0] masked
);
  logic [NPINS-1:0] prev;
  logic [NPINS-1:0] latch;
  logic [NPINS-1:0] edge_hit;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic rise, fall, lvl;
    assign rise = pin_s[i] & ~prev[i];
    assign fall = ~pin_s[i] & prev[i];
    assign lvl  = ~(pin_s[i] ^ pol[i]);
    assign edge_hit[i] = ~sense[i] &
                         (both[i] ? (rise | fall) : (pol[i] ? rise : fall));
    assign raw[i] = sense[i] ? lvl : latch[i];

    // R8
    edge_sets_chk: assert property (@(posedge clk) disable iff (rst)
      edge_hit[i] |=> latch[i]);
    // R7
    clear_drops_chk: assert property (@(posedge clk) disable iff (rst)
      (clr[i] && !edge_hit[i]) |=> !latch[i]);
    // R3
    latch_cause_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(latch[i]) |-> $past(edge_hit[i]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev  <= '0;
      latch <= '0;
    end else begin
      prev  <= pin_s;
      latch <= (latch & ~clr) | edge_hit;
    end
  end

  assign masked = raw & mask;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int NPINS       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [NPINS-1:0]  wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [NPINS-1:0]  rd_data,
  output logic              rd_valid,
  input  logic [NPINS-1:0]  pin_i,
  output logic              irq_o
);
  logic [NPINS-1:0] pin_s, dir_q, sense_q, both_q, pol_q, mask_q, clr;
  logic [NPINS-1:0] raw, masked, rd_mux;

  gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i(pin_i), .q_o(pin_s));

  gpio_cfg_regs #(.NPINS(NPINS)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .dir_q(dir_q), .sense_q(sense_q), .both_q(both_q), .pol_q(pol_q),
    .mask_q(mask_q), .clr_o(clr));

  gpio_pin_detect #(.NPINS(NPINS)) u_det (
    .clk(clk), .rst(rst), .pin_s(pin_s), .sense(sense_q), .both(both_q),
    .pol(pol_q), .mask(mask_q), .clr(clr), .raw(raw), .masked(masked));

  always_comb begin
    case (rd_addr)
      REG_DIR:   rd_mux = dir_q;
      REG_SENSE: rd_mux = sense_q;
      REG_BOTH:  rd_mux = both_q;
      REG_POL:   rd_mux = pol_q;
      REG_MASK:  rd_mux = mask_q;
      REG_RAW:   rd_mux = raw;
      REG_MSKD:  rd_mux = masked;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
      irq_o    <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
      irq_o <= |masked;
    end
  end

  // R9
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_o == $past(|masked)));
  // R10
  rd_valid_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
endmodule

// File: tb/sim_gpio_irq_detect.sv
`timescale 1ns/1ps
module sim_gpio_irq_detect;
  localparam int NP = 12;

  typedef struct {
    logic [NP-1:0] exp;
    string         tag;
  } item_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]    wr_addr = '0, rd_addr = '0;
  logic [NP-1:0] wr_data = '0, pin = '0;
  logic [NP-1:0] rd_data;
  logic          rd_valid, irq;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  item_t q[$];

  always #10 clk = ~clk;

  gpio_irq_detect #(.NPINS(NP)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
    .pin_i(pin), .irq_o(irq));

  localparam logic [2:0] A_DIR = 3'd0, A_SENSE = 3'd1, A_BOTH = 3'd2,
    A_POL = 3'd3, A_MASK = 3'd4, A_RAW = 3'd5, A_MSKD = 3'd6, A_CLR = 3'd7;

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [NP-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [NP-1:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    q.push_back(it);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s irq_o actual=%0b expected=%0b", tag, irq, e);
    end
  endtask

  // monitor: pops expected read results as the design returns them
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      item_t it;
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL unexpected read actual=%h expected=none", rd_data);
      end else begin
        it = q.pop_front();
        if (rd_data !== it.exp) begin
          errors++;
          $display("FAIL %s actual=%h expected=%h", it.tag, rd_data, it.exp);
        end
      end
    end
  end

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(1);
    // R1 reset state
    for (int a = 0; a < 8; a++) rd(3'(a), '0, "R1 reset register");
    chk_irq(1'b0, "R1 reset");
    // R2 readback
    wr(A_DIR, 12'hA5A); rd(A_DIR, 12'hA5A, "R2 direction readback");
    // R3 rising on pin0
    wr(A_POL, 12'h001); wr(A_MASK, 12'h001);
    rd(A_POL, 12'h001, "R2 polarity readback");
    pin[0] = 1'b1; cyc(5);
    rd(A_RAW, 12'h001, "R3 rising edge latched");
    rd(A_MSKD, 12'h001, "R6 unmasked pending");
    chk_irq(1'b1, "R9 irq on masked pending");
    pin[0] = 1'b0; cyc(5);
    rd(A_RAW, 12'h001, "R3 latch held through opposite edge");
    wr(A_CLR, 12'h001); cyc(3);
    rd(A_RAW, 12'h000, "R7 clear by write one");
    chk_irq(1'b0, "R9 irq drops after clear");
    // R3 falling on pin1, masked
    pin[1] = 1'b1; cyc(5);
    rd(A_RAW, 12'h000, "R3 rising ignored for falling pin");
    pin[1] = 1'b0; cyc(5);
    rd(A_RAW, 12'h002, "R3 falling edge latched");
    rd(A_MSKD, 12'h000, "R6 masked pin hidden");
    chk_irq(1'b0, "R6 masked pin gives no irq");
    wr(A_MASK, 12'h003); cyc(3);
    rd(A_MSKD, 12'h002, "R6 unmask shows pending");
    chk_irq(1'b1, "R9 irq after unmask");
    wr(A_CLR, 12'hFFD); cyc(3);
    rd(A_RAW, 12'h002, "R7 zero bits leave latch");
    rd(A_CLR, 12'h000, "R1 clear address reads zero");
    wr(A_CLR, 12'h002); cyc(3);
    rd(A_RAW, 12'h000, "R7 clear pin1");
    chk_irq(1'b0, "R9 irq idle");
    // R4 both edges on pin2 (polarity 0)
    wr(A_BOTH, 12'h004);
    pin[2] = 1'b1; cyc(5);
    rd(A_RAW, 12'h004, "R4 rising with both-edges");
    wr(A_CLR, 12'h004); cyc(3);
    rd(A_RAW, 12'h000, "R7 clear pin2");
    pin[2] = 1'b0; cyc(5);
    rd(A_RAW, 12'h004, "R4 falling with both-edges");
    wr(A_CLR, 12'h004); cyc(3);
    // R10 synchronizer delay on pin5
    wr(A_POL, 12'h021); cyc(1);
    pin[5] = 1'b1; cyc(2);
    rd(A_RAW, 12'h000, "R10 not yet latched at edge 3");
    rd(A_RAW, 12'h020, "R10 latched by edge 4");
    wr(A_CLR, 12'h020); cyc(3);
    // R8 edge meets clear on pin6
    wr(A_POL, 12'h061); cyc(1);
    pin[6] = 1'b1; cyc(2);
    wr(A_CLR, 12'h040); cyc(3);
    rd(A_RAW, 12'h040, "R8 edge wins over clear");
    wr(A_CLR, 12'h040); cyc(3);
    rd(A_RAW, 12'h000, "R7 clear pin6");
    // R5 level HIGH on pin3
    wr(A_SENSE, 12'h008); wr(A_POL, 12'h069); wr(A_MASK, 12'h00B); cyc(3);
    rd(A_RAW, 12'h000, "R5 level low pin idle");
    pin[3] = 1'b1; cyc(5);
    rd(A_RAW, 12'h008, "R5 level high pending");
    chk_irq(1'b1, "R9 irq from level");
    wr(A_CLR, 12'h008); cyc(3);
    rd(A_RAW, 12'h008, "R5 clear ignored for level");
    pin[3] = 1'b0; cyc(5);
    rd(A_RAW, 12'h000, "R5 level follows pin");
    chk_irq(1'b0, "R9 irq gone with level");
    // R5 level LOW on pin4
    wr(A_SENSE, 12'h018); cyc(3);
    rd(A_RAW, 12'h010, "R5 LOW level pending");
    rd(A_MSKD, 12'h000, "R6 LOW level masked");
    pin[4] = 1'b1; cyc(5);
    rd(A_RAW, 12'h000, "R5 LOW level released");
    cyc(3);
    if (q.size() != 0) begin
      errors++;
      $display("FAIL reads missing actual=%0d expected=0", q.size());
    end
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule